// File: doc/BRIEF.md
# Engine Load Monitor

This block estimates how busy four hardware engines are and reports each as an 8-bit load on a 0 to 255 scale. A reference counter advances on every clock of the core. Each of four activity counters watches a shared vector of idle flags through its own mask and counts the clocks in which at least one of its selected flags is low.

A built-in timer ends a sampling window every `PERIOD_US * TICKS_PER_US` clocks. At that point the block snapshots every counter and restarts all of them in the same cycle. A serial divider then turns the snapshots into loads. The new loads replace the visible results in a single commit. A host sends a request with a message identifier and gets back the four loads packed into one 32-bit word over a valid/ready response channel.

The idle inputs are assumed to be synchronous to `clk`. The asynchronous reset is released through a two-stage synchronizer.

Top module: `eng_load_monitor`

## Requirements
- R1: The reference counter rises by exactly one on every core clock. Over a full window it reaches `PERIOD_TICKS = PERIOD_US * TICKS_PER_US`.
- R2: Engine k observes mask bits `cfg_mask_i[k*IDLE_W +: IDLE_W]`. Its counter rises in a clock where at least one masked idle bit is 0. It holds when every masked bit is 1, and it never rises when the mask is all zero. No engine count exceeds the reference count.
- R3: The load equals `floor(engine_count / floor(total / 255))`.
- R4: When `floor(total / 255)` is zero, all four loads are 0.
- R5: A quotient above 255 is reported as 255.
- R6: The first readout is taken on the first clock after the reset synchronizer releases. Later readouts follow every `PERIOD_TICKS` clocks, and the counters restart on each readout.
- R7: A request accepted with `req_id_i` = 1 is answered one clock later. The reply carries engine 3 in bits 31:24, engine 2 in bits 23:16, engine 1 in bits 15:8 and engine 0 in bits 7:0.
- R8: A request with any identifier other than 1 is consumed and gives no reply. `req_data_i` never affects a reply.
- R9: A reply stays valid with stable data until `rsp_ready_i` is high. `req_ready_o` is low while a reply is pending.
- R10: A reply carries the loads from the latest finished readout, never a partial one. After reset the reply is all zero.
- R11: The published loads change only on the commit cycle that ends a readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_i | input | IDLE_W | Shared idle flags, 1 = idle |
| cfg_mask_i | input | 4*IDLE_W | Per-engine selection masks, engine k in slice k |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Block can take a request |
| req_id_i | input | 8 | Request message identifier |
| req_data_i | input | 32 | Request payload, unused |
| rsp_valid_o | output | 1 | Reply valid |
| rsp_ready_i | input | 1 | Host takes the reply |
| rsp_data_o | output | 32 | Packed loads |

## Verification
A reply becomes visible one clock after the request handshake, so the bench looks for it from the next falling edge onward. Loads are committed about `5*(CNT_W+2)` clocks after a window closes. For that reason the bench holds each idle pattern for three full windows of the longest instance, plus margin, before it reads any load. This guarantees that the latest committed window lies wholly inside the pattern. The idle patterns repeat every four clocks and every window length is a multiple of four, so each engine count is exact whatever the phase. Three instances with windows of 1020, 300 and 200 clocks cover the normal division, the saturation case and the zero-quotient case.

// File: rtl/ld_pkg.sv
package ld_pkg;
  localparam int unsigned NUM_ENG  = 4;
  localparam logic [7:0]  MSG_LOAD = 8'd1;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_TOT_GO,
    SQ_TOT_WAIT,
    SQ_ENG_GO,
    SQ_ENG_WAIT,
    SQ_COMMIT
  } seq_state_e;
endpackage

// File: rtl/ld_tick_timer.sv
module ld_tick_timer #(
  parameter int unsigned PERIOD_TICKS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic strobe_o
);
  localparam int unsigned TW = $clog2(PERIOD_TICKS + 1);

  logic [TW-1:0] tmr_q, tmr_d;

  assign strobe_o = (tmr_q == '0);

  always_comb begin
    if (strobe_o) tmr_d = TW'(PERIOD_TICKS - 1);
    else          tmr_d = tmr_q - TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_d;
  end
endmodule

// File: rtl/ld_activity_counters.sv
module ld_activity_counters #(
  parameter int unsigned IDLE_W  = 16,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned NUM_ENG = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr_i,
  input  logic [IDLE_W-1:0]          idle_i,
  input  logic [NUM_ENG*IDLE_W-1:0]  mask_i,
  output logic [CNT_W-1:0]           tot_o,
  output logic [NUM_ENG*CNT_W-1:0]   eng_o
);
  logic [CNT_W-1:0] tot_q, tot_d;

  always_comb begin
    if (clr_i) tot_d = CNT_W'(1);
    else       tot_d = tot_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tot_q <= '0;
    else        tot_q <= tot_d;
  end

  assign tot_o = tot_q;

  for (genvar k = 0; k < NUM_ENG; k++) begin : g_eng
    logic [IDLE_W-1:0] sel;
    logic              busy;
    logic [CNT_W-1:0]  c_q, c_d;

    assign sel  = mask_i[k*IDLE_W +: IDLE_W];
    assign busy = ~&(idle_i | ~sel);

    always_comb begin
      if (clr_i) c_d = CNT_W'(busy);
      else       c_d = c_q + CNT_W'(busy);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) c_q <= '0;
      else        c_q <= c_d;
    end

    assign eng_o[k*CNT_W +: CNT_W] = c_q;
  end
endmodule

// File: rtl/ld_serial_div.sv
module ld_serial_div #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         done_o,
  output logic [W-1:0] quot_o
);
  localparam int unsigned CW = $clog2(W + 1);

  logic          busy_q, busy_d, done_q, done_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  rem_q, rem_d, quo_q, quo_d, dvs_q, dvs_d;
  logic [W:0]    shifted, diff;
  logic          fits;

  assign shifted = {rem_q, quo_q[W-1]};
  assign diff    = shifted - {1'b0, dvs_q};
  assign fits    = (shifted >= {1'b0, dvs_q});

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    cnt_d  = cnt_q;
    rem_d  = rem_q;
    quo_d  = quo_q;
    dvs_d  = dvs_q;
    if (start_i) begin
      busy_d = 1'b1;
      cnt_d  = CW'(W);
      rem_d  = '0;
      quo_d  = dividend_i;
      dvs_d  = divisor_i;
    end else if (busy_q) begin
      rem_d  = fits ? diff[W-1:0] : shifted[W-1:0];
      quo_d  = {quo_q[W-2:0], fits};
      cnt_d  = cnt_q - CW'(1);
      busy_d = (cnt_q != CW'(1));
      done_d = (cnt_q == CW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      dvs_q  <= dvs_d;
    end
  end

  assign done_o = done_q;
  assign quot_o = quo_q;
endmodule

// File: rtl/ld_readout_seq.sv
module ld_readout_seq
  import ld_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      strobe_i,
  input  logic [CNT_W-1:0]          tot_i,
  input  logic [NUM_ENG*CNT_W-1:0]  eng_i,
  output logic [NUM_ENG*8-1:0]      load_o,
  output logic                      commit_o
);
  localparam int unsigned IDX_W = $clog2(NUM_ENG);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENG - 1);

  seq_state_e state_q, state_d;
  logic [IDX_W-1:0]            idx_q, idx_d;
  logic [CNT_W-1:0]            q_q, q_d;
  logic [CNT_W-1:0]            snap_tot_q;
  logic [NUM_ENG*CNT_W-1:0]    snap_eng_q;
  logic [NUM_ENG-1:0][7:0]     res_q, res_d, load_q, load_d;
  logic                        snap_en, div_start, div_done;
  logic [CNT_W-1:0]            div_num, div_den, div_quot;

  function automatic logic [7:0] sat8(input logic [CNT_W-1:0] v);
    if (v > CNT_W'(255)) return 8'hFF;
    return v[7:0];
  endfunction

  assign div_num = (state_q == SQ_TOT_GO) ? snap_tot_q
                                          : snap_eng_q[idx_q*CNT_W +: CNT_W];
  assign div_den = (state_q == SQ_TOT_GO) ? CNT_W'(255) : q_q;

  ld_serial_div #(.W(CNT_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (div_start),
    .dividend_i(div_num),
    .divisor_i (div_den),
    .done_o    (div_done),
    .quot_o    (div_quot)
  );

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    q_d       = q_q;
    res_d     = res_q;
    load_d    = load_q;
    snap_en   = 1'b0;
    div_start = 1'b0;
    commit_o  = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        if (strobe_i) begin
          snap_en = 1'b1;
          state_d = SQ_TOT_GO;
        end
      end
      SQ_TOT_GO: begin
        div_start = 1'b1;
        state_d   = SQ_TOT_WAIT;
      end
      SQ_TOT_WAIT: begin
        if (div_done) begin
          q_d = div_quot;
          if (div_quot == '0) begin
            res_d   = '0;
            state_d = SQ_COMMIT;
          end else begin
            idx_d   = '0;
            state_d = SQ_ENG_GO;
          end
        end
      end
      SQ_ENG_GO: begin
        div_start = 1'b1;
        state_d   = SQ_ENG_WAIT;
      end
      SQ_ENG_WAIT: begin
        if (div_done) begin
          res_d[idx_q] = sat8(div_quot);
          if (idx_q == LAST_IDX) begin
            state_d = SQ_COMMIT;
          end else begin
            idx_d   = idx_q + IDX_W'(1);
            state_d = SQ_ENG_GO;
          end
        end
      end
      SQ_COMMIT: begin
        load_d   = res_q;
        commit_o = 1'b1;
        state_d  = SQ_IDLE;
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      idx_q   <= '0;
      q_q     <= '0;
      res_q   <= '0;
      load_q  <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      q_q     <= q_d;
      res_q   <= res_d;
      load_q  <= load_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_tot_q <= '0;
      snap_eng_q <= '0;
    end else if (snap_en) begin
      snap_tot_q <= tot_i;
      snap_eng_q <= eng_i;
    end
  end

  assign load_o = load_q;
endmodule

// File: rtl/ld_host_port.sv
module ld_host_port
  import ld_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] load_word_i,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic [7:0]  req_id_i,
  output logic        rsp_valid_o,
  input  logic        rsp_ready_i,
  output logic [31:0] rsp_data_o
);
  logic        vld_q, vld_d;
  logic [31:0] dat_q, dat_d;
  logic        take;

  assign req_ready_o = ~vld_q;
  assign take        = req_valid_i & req_ready_o & (req_id_i == MSG_LOAD);

  always_comb begin
    vld_d = vld_q;
    dat_d = dat_q;
    if (take) begin
      vld_d = 1'b1;
      dat_d = load_word_i;
    end else if (vld_q && rsp_ready_i) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      vld_q <= vld_d;
      dat_q <= dat_d;
    end
  end

  assign rsp_valid_o = vld_q;
  assign rsp_data_o  = dat_q;
endmodule

// File: rtl/eng_load_monitor.sv
module eng_load_monitor
  import ld_pkg::*;
#(
  parameter int unsigned IDLE_W       = 16,
  parameter int unsigned CNT_W        = 32,
  parameter int unsigned TICKS_PER_US = 250,
  parameter int unsigned PERIOD_US    = 100000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [IDLE_W-1:0]         idle_i,
  input  logic [4*IDLE_W-1:0]       cfg_mask_i,
  input  logic                      req_valid_i,
  output logic                      req_ready_o,
  input  logic [7:0]                req_id_i,
  input  logic [31:0]               req_data_i,
  output logic                      rsp_valid_o,
  input  logic                      rsp_ready_i,
  output logic [31:0]               rsp_data_o
);
  localparam int unsigned PERIOD_TICKS = PERIOD_US * TICKS_PER_US;

  logic [1:0]               rst_pipe_q;
  logic                     rst_core_n;
  logic                     readout_stb;
  logic                     load_commit;
  logic [CNT_W-1:0]         tot_cnt;
  logic [NUM_ENG*CNT_W-1:0] eng_cnt;
  logic [NUM_ENG*8-1:0]     load_word;
  logic                     unused_data;

  assign unused_data = ^req_data_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  ld_tick_timer #(.PERIOD_TICKS(PERIOD_TICKS)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .strobe_o(readout_stb)
  );

  ld_activity_counters #(
    .IDLE_W (IDLE_W),
    .CNT_W  (CNT_W),
    .NUM_ENG(NUM_ENG)
  ) u_cnt (
    .clk   (clk),
    .rst_n (rst_core_n),
    .clr_i (readout_stb),
    .idle_i(idle_i),
    .mask_i(cfg_mask_i),
    .tot_o (tot_cnt),
    .eng_o (eng_cnt)
  );

  ld_readout_seq #(.CNT_W(CNT_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .strobe_i(readout_stb),
    .tot_i   (tot_cnt),
    .eng_i   (eng_cnt),
    .load_o  (load_word),
    .commit_o(load_commit)
  );

  ld_host_port u_host (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .load_word_i(load_word),
    .req_valid_i(req_valid_i),
    .req_ready_o(req_ready_o),
    .req_id_i   (req_id_i),
    .rsp_valid_o(rsp_valid_o),
    .rsp_ready_i(rsp_ready_i),
    .rsp_data_o (rsp_data_o)
  );
endmodule

// File: rtl/eng_load_monitor_chk.sv
module eng_load_monitor_chk #(
  parameter int unsigned CNT_W        = 32,
  parameter int unsigned NUM_ENG      = 4,
  parameter int unsigned PERIOD_TICKS = 1000
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     stb,
  input logic                     commit,
  input logic [CNT_W-1:0]         tot,
  input logic [NUM_ENG*CNT_W-1:0] eng,
  input logic [NUM_ENG*8-1:0]     load_word,
  input logic                     req_valid,
  input logic                     req_ready,
  input logic [7:0]               req_id,
  input logic                     rsp_valid,
  input logic                     rsp_ready,
  input logic [31:0]              rsp_data
);
  logic        seen_q;
  logic [31:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      gap_q  <= '0;
    end else if (stb) begin
      seen_q <= 1'b1;
      gap_q  <= '0;
    end else begin
      gap_q  <= gap_q + 32'd1;
    end
  end

  AST_TOTAL_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> tot == $past(tot) + CNT_W'(1)); // R1

  AST_TOTAL_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> tot == CNT_W'(1)); // R6

  AST_READOUT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && seen_q) |-> gap_q == 32'(PERIOD_TICKS - 1)); // R6

  for (genvar k = 0; k < NUM_ENG; k++) begin : g_le
    AST_ENG_NOT_ABOVE_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
      eng[k*CNT_W +: CNT_W] <= tot); // R2
  end

  AST_LOAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(load_word)); // R11

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R9

  AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R9

  AST_LOAD_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_id == 8'd1) |=>
      (rsp_valid && rsp_data == $past(load_word))); // R7 R10

  AST_OTHER_ID_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_id != 8'd1) |=> !rsp_valid); // R8
endmodule

bind eng_load_monitor eng_load_monitor_chk #(
  .CNT_W       (CNT_W),
  .NUM_ENG     (NUM_ENG),
  .PERIOD_TICKS(PERIOD_TICKS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_core_n),
  .stb      (readout_stb),
  .commit   (load_commit),
  .tot      (tot_cnt),
  .eng      (eng_cnt),
  .load_word(load_word),
  .req_valid(req_valid_i),
  .req_ready(req_ready_o),
  .req_id   (req_id_i),
  .rsp_valid(rsp_valid_o),
  .rsp_ready(rsp_ready_i),
  .rsp_data (rsp_data_o)
);

// File: tb/eng_load_monitor_tb.sv
module eng_load_monitor_tb;
  localparam int IW = 8;
  localparam int P0 = 1020;
  localparam int P1 = 300;
  localparam int P2 = 200;
  localparam int SETTLE = 3 * P0 + 300;
  localparam logic [7:0] M0 = 8'h03, M1 = 8'h04, M2 = 8'h08, M3 = 8'h00;
  localparam int NROWS = 6;
  // Each row: {idle pattern on phase 0, idle pattern on phases 1..3}
  localparam logic [15:0] ROWS [NROWS] = '{
    16'hFFFF, 16'h0000, 16'h00FF, 16'hFF00, 16'hFEFF, 16'hF7FB
  };

  logic clk, rst_n;
  logic [IW-1:0]   idle;
  logic [4*IW-1:0] mask;
  logic [7:0] pat_a, pat_b;
  logic        req_valid [3];
  logic        req_ready [3];
  logic [7:0]  req_id    [3];
  logic [31:0] req_data  [3];
  logic        rsp_valid [3];
  logic        rsp_ready [3];
  logic [31:0] rsp_data  [3];
  int checks, errors;

  assign mask = {M3, M2, M1, M0};

  eng_load_monitor #(.IDLE_W(IW), .CNT_W(32), .TICKS_PER_US(1), .PERIOD_US(P0)) u_dut (
    .clk(clk), .rst_n(rst_n), .idle_i(idle), .cfg_mask_i(mask),
    .req_valid_i(req_valid[0]), .req_ready_o(req_ready[0]), .req_id_i(req_id[0]),
    .req_data_i(req_data[0]), .rsp_valid_o(rsp_valid[0]), .rsp_ready_i(rsp_ready[0]),
    .rsp_data_o(rsp_data[0]));

  eng_load_monitor #(.IDLE_W(IW), .CNT_W(32), .TICKS_PER_US(1), .PERIOD_US(P1)) u_dut_sat (
    .clk(clk), .rst_n(rst_n), .idle_i(idle), .cfg_mask_i(mask),
    .req_valid_i(req_valid[1]), .req_ready_o(req_ready[1]), .req_id_i(req_id[1]),
    .req_data_i(req_data[1]), .rsp_valid_o(rsp_valid[1]), .rsp_ready_i(rsp_ready[1]),
    .rsp_data_o(rsp_data[1]));

  eng_load_monitor #(.IDLE_W(IW), .CNT_W(32), .TICKS_PER_US(1), .PERIOD_US(P2)) u_dut_zero (
    .clk(clk), .rst_n(rst_n), .idle_i(idle), .cfg_mask_i(mask),
    .req_valid_i(req_valid[2]), .req_ready_o(req_ready[2]), .req_id_i(req_id[2]),
    .req_data_i(req_data[2]), .rsp_valid_o(rsp_valid[2]), .rsp_ready_i(rsp_ready[2]),
    .rsp_data_o(rsp_data[2]));

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  // idle driver: pattern A on one clock in four, pattern B on the other three
  initial begin
    logic [1:0] ph;
    ph = 2'd0;
    idle = 8'hFF;
    forever begin
      @(negedge clk);
      ph = ph + 2'd1;
      idle = (ph == 2'd0) ? pat_a : pat_b;
    end
  end

  function automatic logic [7:0] exp_load(input logic [7:0] a, input logic [7:0] b,
                                          input logic [7:0] m, input int p);
    int c, q;
    c = 0;
    if ((a & m) != m) c += p / 4;
    if ((b & m) != m) c += 3 * p / 4;
    q = p / 255;
    if (q == 0) return 8'd0;
    if (c / q > 255) return 8'd255;
    return 8'(c / q);
  endfunction

  function automatic logic [31:0] exp_word(input logic [7:0] a, input logic [7:0] b, input int p);
    return {exp_load(a, b, M3, p), exp_load(a, b, M2, p), exp_load(a, b, M1, p), exp_load(a, b, M0, p)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic host_query(input int d, input logic [7:0] id, input logic [31:0] dat,
                            output logic got, output logic [31:0] word);
    word = '0;
    got  = 1'b0;
    @(negedge clk);
    req_valid[d] = 1'b1;
    req_id[d]    = id;
    req_data[d]  = dat;
    while (!req_ready[d]) @(negedge clk);
    @(negedge clk);
    req_valid[d] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (rsp_valid[d]) begin
        got  = 1'b1;
        word = rsp_data[d];
        break;
      end
      @(negedge clk);
    end
    if (got) begin
      rsp_ready[d] = 1'b1;
      @(negedge clk);
      rsp_ready[d] = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic got;
    logic [31:0] w, w2;
    int plist [3];
    plist[0] = P0; plist[1] = P1; plist[2] = P2;
    checks = 0;
    errors = 0;
    pat_a = 8'hFF;
    pat_b = 8'hFF;
    for (int d = 0; d < 3; d++) begin
      req_valid[d] = 1'b0; req_id[d] = '0; req_data[d] = '0; rsp_ready[d] = 1'b0;
    end
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: reset state and first reply
    check(req_ready[0] && !rsp_valid[0], "R10 reset handshake", {30'd0, req_ready[0], rsp_valid[0]}, 32'd2);
    host_query(0, 8'd1, 32'd0, got, w);
    check(got && w == 32'd0, "R10 reset reply", w, 32'd0);

    // table of idle patterns over all three instances (R1 R2 R3 R4 R5 R6 R7)
    for (int r = 0; r < NROWS; r++) begin
      pat_a = ROWS[r][15:8];
      pat_b = ROWS[r][7:0];
      repeat (SETTLE) @(negedge clk);
      for (int d = 0; d < 3; d++) begin
        host_query(d, 8'd1, 32'h0, got, w);
        check(got && w == exp_word(pat_a, pat_b, plist[d]),
              (d == 0) ? "R3 R7 load word" : (d == 1) ? "R5 saturated word" : "R4 zero quotient word",
              w, exp_word(pat_a, pat_b, plist[d]));
      end
    end

    // R8: other identifier gets no reply, payload ignored
    host_query(0, 8'd2, 32'h1234_5678, got, w);
    check(!got, "R8 other id silent", {31'd0, got}, 32'd0);
    host_query(0, 8'd1, 32'h0, got, w);
    host_query(0, 8'd1, 32'hDEAD_BEEF, got, w2);
    check(got && w2 == w, "R8 payload ignored", w2, w);
    check(w == exp_word(pat_a, pat_b, P0), "R1 R6 window length via load", w, exp_word(pat_a, pat_b, P0));

    // R9: reply held while host stalls
    @(negedge clk);
    req_valid[0] = 1'b1; req_id[0] = 8'd1;
    @(negedge clk);
    req_valid[0] = 1'b0;
    w = rsp_data[0];
    repeat (4) @(negedge clk);
    check(rsp_valid[0] && !req_ready[0] && rsp_data[0] == w, "R9 reply held", rsp_data[0], w);
    rsp_ready[0] = 1'b1;
    @(negedge clk);
    rsp_ready[0] = 1'b0;
    check(!rsp_valid[0] && req_ready[0], "R9 reply released", {30'd0, rsp_valid[0], req_ready[0]}, 32'd1);

    // R11: loads unchanged while pattern changes but no new window completes
    pat_a = 8'h00; pat_b = 8'h00;
    repeat (10) @(negedge clk);
    host_query(0, 8'd1, 32'h0, got, w2);
    check(got && w2 == w, "R11 loads stable before commit", w2, w);

    // R2: mask of zero never counts even when fully busy
    repeat (SETTLE) @(negedge clk);
    host_query(0, 8'd1, 32'h0, got, w);
    check(got && w[31:24] == 8'd0 && w[7:0] == 8'd255, "R2 empty mask and full busy", w, 32'h00FF_FFFF & w | 32'h0000_00FF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule